// File: doc/BRIEF.md
# Keyed Configuration Byte Port

This block gives boot firmware a narrow window onto a table of configuration items. Firmware first writes a 16-bit key to a write-only selector. It then reads or writes an 8-bit data register, one byte per access, and an internal byte offset steps through the chosen item. Items sit in an on-chip byte array split into two banks, a generic bank and an architecture-local bank, each holding `NUM_ENTRIES` items of up to `DEPTH` bytes with a 16-bit length per item.

Two flag bits in the key steer the access. Bit 15 picks the local bank and bit 14 marks the item as a writable channel. Bits 13:0 form the index field. When a writable channel receives its last byte, the block emits a one-cycle completion pulse and returns the offset to zero, so the same channel can be filled again. Host software loads item contents and lengths through a separate preload port before firmware runs. Generic item 0 comes out of reset holding a 4-byte ASCII signature that lets firmware detect the device.

Top module: `cfg_port_dev`

## Requirements
- R1: After reset, key 0 is selected with offset 0, `dat_rdata` is 0 and `done_pulse` is low; the next data read returns the first signature byte.
- R2: Generic item 0 resets to length 4 and holds `SIGNATURE` with its most significant character at byte 0 ("CFGD" by default: 0x43, 0x46, 0x47, 0x44); a fifth read returns 0.
- R3: Any selector write clears the byte offset, so selecting the same key again restarts the item at byte 0.
- R4: Key bit 15 set selects the local bank and clear selects the generic bank; the index field in bits 13:0 picks the item within the bank.
- R5: An index field at or above `NUM_ENTRIES` marks the selection invalid: reads return 0 and data writes change no stored byte and raise no completion.
- R6: A data read returns the byte at the current offset (visible on `dat_rdata` one cycle later) and advances the offset; at or past the item length, or for an empty item, the read returns 0 and the offset holds.
- R7: Bytes come out in ascending byte address, so a 32-bit value preloaded least significant byte first (0x11223344 as 44,33,22,11) reads back least significant byte first.
- R8: A data write is stored at the current offset and advances it only when key bit 14 is set and the offset is below the item length; otherwise it has no effect.
- R9: The accepted write that fills the last byte of an item produces a one-cycle `done_pulse`, with `done_bank` and `done_idx` naming that item, and returns the offset to 0.
- R10: A length larger than `DEPTH` acts as `DEPTH`: reads stop returning data after `DEPTH` bytes.
- R11: At most one of `sel_we`, `dat_re`, `dat_we`, `pre_we`, `pre_len_we` is high in a cycle, and `dat_rdata` changes only in the cycle after a data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | Key written to the selector |
| dat_re | input | 1 | Data read strobe |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Byte written to the data register |
| dat_rdata | output | 8 | Byte returned by the last data read |
| pre_we | input | 1 | Preload byte write strobe |
| pre_len_we | input | 1 | Preload length write strobe |
| pre_bank | input | 1 | Preload bank (1 = local) |
| pre_idx | input | IDX_W | Preload item index |
| pre_addr | input | AW | Preload byte address within the item |
| pre_data | input | 8 | Preload byte |
| pre_len | input | 16 | Preload item length |
| done_pulse | output | 1 | One-cycle fill-complete pulse |
| done_bank | output | 1 | Bank of the completed item |
| done_idx | output | IDX_W | Index of the completed item |

## Verification
Reads are tried on the signature, on a 4-byte little-endian integer, on a 2-byte local item at the same index as a generic one, on an empty item and on an over-long item. The read results tell bank steering apart from index decoding, and they show where end-of-item zeros start. Invalid keys whose low bits alias a valid item (0x2000, 0x0009) show that the full index field is compared and not just its low bits. Write sequences on a writable channel, on a read-only key and on an invalid key separate the accept condition from the completion and rewind. A refill after completion confirms that the offset restarted at byte 0.

// File: rtl/cfg_port_dev.sv
module cfg_port_dev #(
  parameter int          NUM_ENTRIES = 8,
  parameter int          DEPTH       = 16,
  parameter int          BANK_BIT    = 15,
  parameter int          WCH_BIT     = 14,
  parameter logic [31:0] SIGNATURE   = 32'h43464744,
  localparam int         IDX_W       = $clog2(NUM_ENTRIES),
  localparam int         AW          = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [15:0]      sel_wdata,
  input  logic             dat_re,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  output logic [7:0]       dat_rdata,
  input  logic             pre_we,
  input  logic             pre_len_we,
  input  logic             pre_bank,
  input  logic [IDX_W-1:0] pre_idx,
  input  logic [AW-1:0]    pre_addr,
  input  logic [7:0]       pre_data,
  input  logic [15:0]      pre_len,
  output logic             done_pulse,
  output logic             done_bank,
  output logic [IDX_W-1:0] done_idx
);
  localparam int NSLOT = 2 * NUM_ENTRIES;
  localparam int NBYTE = NSLOT * DEPTH;
  localparam int SW    = $clog2(NSLOT);
  localparam int NBW   = $clog2(NBYTE);
  localparam logic [WCH_BIT-1:0] NUM_E = WCH_BIT'(NUM_ENTRIES);
  localparam logic [15:0]        DEPTH_L = 16'(DEPTH);

  logic             bank_q, wch_q, valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      off_q;
  logic [15:0]      len_q [NSLOT];
  logic [7:0]       mem_q [NBYTE];

  logic [SW-1:0]  cur_slot, pre_slot;
  logic [NBW-1:0] cur_addr, pre_lin;
  logic [15:0]    raw_len, cur_len;
  logic           rd_ok, wr_go, last, pre_ok;

  assign cur_slot = SW'(idx_q) + (bank_q ? SW'(NUM_ENTRIES) : SW'(0));
  assign pre_slot = SW'(pre_idx) + (pre_bank ? SW'(NUM_ENTRIES) : SW'(0));
  assign cur_addr = NBW'(cur_slot) * NBW'(DEPTH) + NBW'(off_q[AW-1:0]);
  assign pre_lin  = NBW'(pre_slot) * NBW'(DEPTH) + NBW'(pre_addr);
  assign pre_ok   = 32'(pre_idx) < NUM_ENTRIES;

  assign raw_len = len_q[cur_slot];
  assign cur_len = !valid_q ? 16'd0 : (raw_len > DEPTH_L ? DEPTH_L : raw_len);
  assign rd_ok   = off_q < cur_len;
  assign wr_go   = dat_we && !sel_we && !dat_re && wch_q && rd_ok;
  assign last    = wr_go && (off_q + 16'd1 == cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q     <= 1'b0;
      wch_q      <= 1'b0;
      idx_q      <= '0;
      valid_q    <= 1'b1;
      off_q      <= '0;
      dat_rdata  <= '0;
      done_pulse <= 1'b0;
      done_bank  <= 1'b0;
      done_idx   <= '0;
    end else begin
      done_pulse <= last;
      if (last) begin
        done_bank <= bank_q;
        done_idx  <= idx_q;
      end
      if (sel_we) begin
        bank_q  <= sel_wdata[BANK_BIT];
        wch_q   <= sel_wdata[WCH_BIT];
        idx_q   <= sel_wdata[IDX_W-1:0];
        valid_q <= sel_wdata[WCH_BIT-1:0] < NUM_E;
        off_q   <= '0;
      end else if (dat_re) begin
        dat_rdata <= rd_ok ? mem_q[cur_addr] : 8'h00;
        if (rd_ok) off_q <= off_q + 16'd1;
      end else if (wr_go) begin
        off_q <= last ? 16'd0 : off_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++)
        mem_q[i] <= (i < 4) ? SIGNATURE[31-8*i -: 8] : 8'h00;
      for (int s = 0; s < NSLOT; s++)
        len_q[s] <= (s == 0) ? 16'd4 : 16'd0;
    end else begin
      if (pre_we && pre_ok)
        mem_q[pre_lin] <= pre_data;
      else if (wr_go)
        mem_q[cur_addr] <= dat_wdata;
      if (pre_len_we && pre_ok)
        len_q[pre_slot] <= pre_len;
    end
  end

  // R3
  sel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> off_q == 16'd0);

  // R9
  done_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (off_q == 16'd0) && $past(dat_we));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && !sel_we && !rd_ok) |=> $stable(off_q));

  // R5
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && !sel_we && !valid_q) |=> dat_rdata == 8'h00);

  // R11
  one_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_we, dat_re, dat_we, pre_we, pre_len_we}));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_re |=> $stable(dat_rdata));
endmodule

// File: tb/cfg_port_dev_bench.sv
module cfg_port_dev_bench;
  localparam int IDX_W = 3;
  localparam int AW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_we = 0, dat_re = 0, dat_we = 0, pre_we = 0, pre_len_we = 0, pre_bank = 0;
  logic [15:0] sel_wdata = '0, pre_len = '0;
  logic [7:0]  dat_wdata = '0, pre_data = '0, dat_rdata;
  logic [IDX_W-1:0] pre_idx = '0, done_idx;
  logic [AW-1:0]    pre_addr = '0;
  logic done_pulse, done_bank;

  int checks = 0, failures = 0;
  bit finished = 0;

  cfg_port_dev u_cfg_port_dev (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .dat_re(dat_re), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .pre_we(pre_we), .pre_len_we(pre_len_we), .pre_bank(pre_bank), .pre_idx(pre_idx),
    .pre_addr(pre_addr), .pre_data(pre_data), .pre_len(pre_len),
    .done_pulse(done_pulse), .done_bank(done_bank), .done_idx(done_idx));

  always #2 clk = ~clk;

  // {req[3:0], op[1:0] (0 select, 1 read-and-check), arg[15:0], expected byte}
  localparam int NV = 27;
  localparam logic [29:0] VEC [NV] = '{
    {4'd2, 2'd1, 16'h0000, 8'h43},  // R2 signature byte 0
    {4'd2, 2'd1, 16'h0000, 8'h46},  // R2
    {4'd2, 2'd1, 16'h0000, 8'h47},  // R2
    {4'd2, 2'd1, 16'h0000, 8'h44},  // R2
    {4'd6, 2'd1, 16'h0000, 8'h00},  // R6 past end
    {4'd0, 2'd0, 16'h0001, 8'h00},
    {4'd7, 2'd1, 16'h0000, 8'h44},  // R7 LSB first
    {4'd7, 2'd1, 16'h0000, 8'h33},  // R7
    {4'd0, 2'd0, 16'h0001, 8'h00},  // R3 reselect
    {4'd3, 2'd1, 16'h0000, 8'h44},  // R3 restart at byte 0
    {4'd7, 2'd1, 16'h0000, 8'h33},  // R7
    {4'd7, 2'd1, 16'h0000, 8'h22},  // R7
    {4'd7, 2'd1, 16'h0000, 8'h11},  // R7
    {4'd6, 2'd1, 16'h0000, 8'h00},  // R6
    {4'd6, 2'd1, 16'h0000, 8'h00},  // R6 offset held
    {4'd0, 2'd0, 16'h8001, 8'h00},
    {4'd4, 2'd1, 16'h0000, 8'hA0},  // R4 local bank
    {4'd4, 2'd1, 16'h0000, 8'hA1},  // R4
    {4'd6, 2'd1, 16'h0000, 8'h00},  // R6
    {4'd0, 2'd0, 16'h0009, 8'h00},
    {4'd5, 2'd1, 16'h0000, 8'h00},  // R5 index 9
    {4'd0, 2'd0, 16'h2000, 8'h00},
    {4'd5, 2'd1, 16'h0000, 8'h00},  // R5 large index, low bits 0
    {4'd0, 2'd0, 16'h0005, 8'h00},
    {4'd6, 2'd1, 16'h0000, 8'h00},  // R6 empty item
    {4'd0, 2'd0, 16'h8000, 8'h00},
    {4'd4, 2'd1, 16'h0000, 8'h00}   // R4 local item 0 is empty
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic sel(input logic [15:0] k);
    @(negedge clk); sel_we = 1; sel_wdata = k;
    @(negedge clk); sel_we = 0;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0; b = dat_rdata;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); dat_we = 1; dat_wdata = b;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic pbyte(input logic bk, input int idx, input int a, input logic [7:0] d);
    @(negedge clk); pre_we = 1; pre_bank = bk; pre_idx = IDX_W'(idx); pre_addr = AW'(a); pre_data = d;
    @(negedge clk); pre_we = 0;
  endtask

  task automatic plen(input logic bk, input int idx, input logic [15:0] l);
    @(negedge clk); pre_len_we = 1; pre_bank = bk; pre_idx = IDX_W'(idx); pre_len = l;
    @(negedge clk); pre_len_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    chk("R1 rdata after reset", 16'(dat_rdata), 16'h00);
    chk("R1 done after reset", 16'(done_pulse), 16'h0);

    pbyte(0, 1, 0, 8'h44); pbyte(0, 1, 1, 8'h33); pbyte(0, 1, 2, 8'h22); pbyte(0, 1, 3, 8'h11);
    plen(0, 1, 16'd4);
    pbyte(1, 1, 0, 8'hA0); pbyte(1, 1, 1, 8'hA1); plen(1, 1, 16'd2);
    plen(0, 2, 16'd3);
    plen(1, 3, 16'd1);
    for (int i = 0; i < 16; i++) pbyte(0, 4, i, 8'(i + 1));
    plen(0, 4, 16'd100);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][25:24] == 2'd0) sel(VEC[v][23:8]);
      else begin
        rd(b);
        chk($sformatf("R%0d vector %0d", VEC[v][29:26], v), 16'(b), 16'(VEC[v][7:0]));
      end
    end

    // R8 R9 fill a writable channel
    sel(16'h4002);
    wr(8'h5A); chk("R9 no done early", 16'(done_pulse), 16'h0);
    wr(8'h5B); chk("R9 no done early", 16'(done_pulse), 16'h0);
    wr(8'h5C);
    chk("R9 done on last byte", 16'(done_pulse), 16'h1);
    chk("R9 done bank/index", {done_bank, 12'h0, done_idx}, 16'h0002);
    idle();
    chk("R9 done one cycle", 16'(done_pulse), 16'h0);
    wr(8'h77);
    sel(16'h0002);
    rd(b); chk("R9 rewind then refill byte 0", 16'(b), 16'h77);
    rd(b); chk("R8 stored byte 1", 16'(b), 16'h5B);
    rd(b); chk("R8 stored byte 2", 16'(b), 16'h5C);

    // R8 write without the channel flag is ignored
    sel(16'h0001); wr(8'hEE);
    sel(16'h0001); rd(b); chk("R8 read-only key untouched", 16'(b), 16'h44);

    // R5 write to invalid key aliasing item 1
    sel(16'h4009); wr(8'h55);
    chk("R5 no done on invalid", 16'(done_pulse), 16'h0);
    sel(16'h0001); rd(b); chk("R5 invalid write ignored", 16'(b), 16'h44);

    // R4 R9 local bank channel
    sel(16'hC003); wr(8'h99);
    chk("R9 done local", 16'(done_pulse), 16'h1);
    chk("R4 done bank/index", {done_bank, 12'h0, done_idx}, 16'h8003);

    // R10 length clamp
    sel(16'h0004);
    for (int i = 0; i < 16; i++) begin
      rd(b); chk("R10 clamped item data", 16'(b), 16'(i + 1));
    end
    rd(b); chk("R10 stop at DEPTH", 16'(b), 16'h00);

    // R11 rdata holds across idle and select
    sel(16'h0001); rd(b);
    idle(); idle(); idle();
    sel(16'h0002);
    chk("R11 rdata held", 16'(dat_rdata), 16'h44);

    // R1 reset mid-run
    sel(16'h0001); rd(b);
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    chk("R1 rdata cleared", 16'(dat_rdata), 16'h00);
    chk("R1 done cleared", 16'(done_pulse), 16'h0);
    rd(b); chk("R1 key 0 reselected", 16'(b), 16'h43);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule